// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge gives a host a narrow window of eight 16-bit slots and, through it, reach into a larger bank of internal registers. The window holds a control/status register, a read-only revision word, an address register and four data registers. Software loads the data registers and then writes an address word. That write alone starts one internal transaction. A busy flag stays up for a fixed number of cycles while the transaction runs.

An internal register can be wider than 16 bits. A write to it takes its words from the four data registers, all committed in the same cycle. A read returns one 16-bit word, chosen by a word index in the address, and places it in data register 0. Software repeats the read once for each index.

The internal bank is a small behavioural model. It has a relay control bit, a five-bit port enable mask, three clock generators (each with a source select and a 32-bit ratio) and a 64-bit timestamp register.

Top module: `indirect_reg_bridge`

## Requirements
- R1: Window offsets (host_off) are 0 control/status, 1 revision, 2 address, 3 to 6 data registers 0 to 3. Offset 7 reads 0 and ignores writes. host_rdata shows the addressed slot in the same cycle.
- R2: The revision word is read-only: bit 15 = NOT audio_present, bits 14:12 = BOARD_REV, bits 7:4 = MAJOR_REV, bits 3:0 = MINOR_REV, other bits 0. Host writes to it have no effect.
- R3: In the status word, bit 0 is the read-only busy flag, bit 2 drives quad_mode, bit 3 drives glob_rst_n and bit 4 drives codec_rst_n. Bits 2 to 4 are writable. All other bits read 0. All three control bits reset to 0.
- R4: The address word holds bits 15:12 block type, 11:8 instance, 7 direction (1 read, 0 write), 3:2 parameter and 1:0 word index. A write to offset 2 while idle stores the word and starts a transaction. Busy then reads 1 for exactly BUSY_CYCLES samples after the write edge and 0 after that, once the transaction is complete.
- R5: A write to offset 2 while busy is ignored. The address register keeps its value and no second transaction starts.
- R6: Writes to the data registers alone never change an internal register.
- R7: An internal write takes word k from data register k, using the values held at the address write. All words are committed together at the end of busy. Later data register writes do not alter it.
- R8: An internal read loads data register 0 at the end of busy with the word selected by the index. An index beyond the register's width returns 0. The read result overrides a host write to data register 0 in the same cycle.
- R9: An address that selects no implemented register completes normally. A read of it returns 0 and a write to it changes nothing.
- R10: Map: relay (type 9, instance 1, parameter 0, 1 bit, also on relay_out); port enable (type 9, instance 1, parameter 1, 5 bits); clock generator n for n = 1 to 3 (type 2, instance n, parameter 1 = 2-bit source, parameter 2 = 32-bit ratio); timestamp (type 3, instance 1, parameter 1, 64 bits). Unused bits read 0.
- R11: After reset, the address register, all data registers and all internal registers are 0, and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the addressed slot |
| host_off | input | 3 | Window slot offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the addressed slot |
| audio_present | input | 1 | Audio hardware fitted (reflected inverted in revision bit 15) |
| quad_mode | output | 1 | Codec mode control bit |
| glob_rst_n | output | 1 | Active-low global reset control |
| codec_rst_n | output | 1 | Active-low codec reset control |
| relay_out | output | 1 | Relay control state |

## Verification
Window reads are combinational. Control pins follow a status write from the next cycle on. The bench samples at the falling edge, one half cycle after each driven edge. Busy is sampled in each of the BUSY_CYCLES cycles after the address write edge and is expected clear in the next one. An internal write or read result is due at the edge that ends busy, so every transaction is followed by exactly BUSY_CYCLES idle cycles before its effect is read back through data register 0 or relay_out. Stimulus that must be ignored is issued inside the busy window, and its effect is read back once that window has closed.

// File: rtl/ibr_pkg.sv
// Package: shared encodings of the indirect register bridge.
// Assumes a 16-bit host window with eight slots.
package ibr_pkg;

    localparam int WORD_W = 16;
    localparam int NUM_DATA = 4;

    // host window slot offsets
    localparam logic [2:0] OFF_STATUS = 3'd0;
    localparam logic [2:0] OFF_REV    = 3'd1;
    localparam logic [2:0] OFF_ADDR   = 3'd2;
    localparam logic [2:0] OFF_DATA0  = 3'd3;

    // block type codes in the address word
    localparam logic [3:0] TYPE_PORT   = 4'd1;
    localparam logic [3:0] TYPE_CLKGEN = 4'd2;
    localparam logic [3:0] TYPE_TIMER  = 4'd3;
    localparam logic [3:0] TYPE_GLOBAL = 4'd9;

    // fields of an accepted address word that the sequencer keeps
    typedef struct packed {
        logic [3:0] blk_type;
        logic [3:0] inst;
        logic       is_read;
        logic [1:0] param;
        logic [1:0] idx;
    } ibr_target_t;

endpackage

// File: rtl/ibr_window.sv
// Module: host-facing window of the bridge.
// Holds the status control bits, the address register and the four data
// registers, builds the revision word, and gates address writes with busy.
// Assumes host writes take effect on the rising edge where host_wr is high.
module ibr_window
    import ibr_pkg::*;
#(
    parameter int BOARD_REV = 5,
    parameter int MAJOR_REV = 2,
    parameter int MINOR_REV = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic [2:0]                 host_off,
    input  logic [WORD_W-1:0]          host_wdata,
    output logic [WORD_W-1:0]          host_rdata,
    input  logic                       audio_present,
    input  logic                       busy,
    input  logic                       rd_load,
    input  logic [WORD_W-1:0]          rd_word,
    output logic                       launch,
    output ibr_target_t                launch_tgt,
    output logic [NUM_DATA*WORD_W-1:0] data_flat,
    output logic                       quad_mode,
    output logic                       glob_rst_n,
    output logic                       codec_rst_n
);

    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q [NUM_DATA];
    logic [2:0]        ctrl_q;     // {codec_rst_n, glob_rst_n, quad_mode}
    logic [WORD_W-1:0] rev_word;
    logic              wr_status;
    logic              wr_addr;

    assign wr_status = host_wr && (host_off == OFF_STATUS);
    assign wr_addr   = host_wr && (host_off == OFF_ADDR);
    assign launch    = wr_addr && !busy;

    assign launch_tgt.blk_type = host_wdata[15:12];
    assign launch_tgt.inst     = host_wdata[11:8];
    assign launch_tgt.is_read  = host_wdata[7];
    assign launch_tgt.param    = host_wdata[3:2];
    assign launch_tgt.idx      = host_wdata[1:0];

    assign rev_word = {~audio_present, 3'(BOARD_REV), 4'd0,
                       4'(MAJOR_REV), 4'(MINOR_REV)};

    assign quad_mode   = ctrl_q[0];
    assign glob_rst_n  = ctrl_q[1];
    assign codec_rst_n = ctrl_q[2];

    // Purpose: keep the writable status control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_status) begin
            ctrl_q <= host_wdata[4:2];
        end
    end

    // Purpose: store an address word only when it starts a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (launch) begin
            addr_q <= host_wdata;
        end
    end

    // Purpose: host writes to data registers; a read result wins on slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_DATA; k++) begin
                data_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_DATA; k++) begin
                if (host_wr && (host_off == 3'(int'(OFF_DATA0) + k))) begin
                    data_q[k] <= host_wdata;
                end
            end
            if (rd_load) begin
                data_q[0] <= rd_word;
            end
        end
    end

    // Purpose: flatten data registers for the sequencer snapshot.
    always_comb begin
        for (int k = 0; k < NUM_DATA; k++) begin
            data_flat[k*WORD_W +: WORD_W] = data_q[k];
        end
    end

    // Purpose: combinational read mux over the window slots.
    always_comb begin
        host_rdata = '0;
        case (host_off)
            OFF_STATUS: host_rdata = {11'd0, ctrl_q, 1'b0, busy};
            OFF_REV:    host_rdata = rev_word;
            OFF_ADDR:   host_rdata = addr_q;
            3'd3:       host_rdata = data_q[0];
            3'd4:       host_rdata = data_q[1];
            3'd5:       host_rdata = data_q[2];
            3'd6:       host_rdata = data_q[3];
            default:    host_rdata = '0;
        endcase
    end

    // R5: an address write during busy leaves the address register alone
    a_r5_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr && busy) |=> $stable(addr_q));

    // R8: data register 0 changes only through a host write or a read result
    a_r8_data0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_wr && host_off == OFF_DATA0) && !rd_load) |=> $stable(data_q[0]));

    // R3: control pins change only after a status write
    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ($stable(quad_mode) && $stable(glob_rst_n) && $stable(codec_rst_n)));

endmodule

// File: rtl/ibr_sequencer.sv
// Module: transaction sequencer.
// Snapshots the target fields and data words on launch, holds busy for
// BUSY_CYCLES cycles, and issues one write or read strobe as busy ends.
// Assumes launch is never raised while busy (the window gates it).
module ibr_sequencer
    import ibr_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch,
    input  ibr_target_t                launch_tgt,
    input  logic [NUM_DATA*WORD_W-1:0] data_flat,
    output logic                       busy,
    output logic                       commit_wr,
    output logic                       commit_rd,
    output ibr_target_t                tgt,
    output logic [NUM_DATA*WORD_W-1:0] wdata
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last_cycle;

    assign busy       = (cnt_q != '0);
    assign last_cycle = (cnt_q == CNT_W'(1));
    assign commit_wr  = last_cycle && !tgt.is_read;
    assign commit_rd  = last_cycle && tgt.is_read;

    // Purpose: count the busy window down from launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (launch) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (busy) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Purpose: freeze the target and data words of the running transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt   <= '0;
            wdata <= '0;
        end else if (launch) begin
            tgt   <= launch_tgt;
            wdata <= data_flat;
        end
    end

    // R4: a launch raises busy on the next cycle
    a_r4_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    // R5: the window never launches while busy
    a_r5_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);

    // R4: busy is gone right after the commit strobe
    a_r4_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr || commit_rd) |=> !busy);

    // R4: at most one strobe per transaction, and only while busy
    a_r4_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr || commit_rd) |-> (busy && $onehot0({commit_wr, commit_rd})));

endmodule

// File: rtl/ibr_regfile.sv
// Module: behavioural internal register bank.
// Decodes type/instance/parameter, commits wide writes in one cycle and
// returns one 16-bit word of the selected register by word index.
// Assumes wr_en is a single-cycle strobe from the sequencer.
module ibr_regfile
    import ibr_pkg::*;
#(
    parameter int NUM_CLKGEN = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  ibr_target_t                tgt,
    input  logic [NUM_DATA*WORD_W-1:0] wdata,
    output logic [WORD_W-1:0]          rdata,
    output logic                       relay_out
);

    localparam int REG_W = NUM_DATA * WORD_W;

    logic              relay_q;
    logic [4:0]        porten_q;
    logic [REG_W-1:0]  stamp_q;
    logic [1:0]        src_arr   [NUM_CLKGEN];
    logic [31:0]       ratio_arr [NUM_CLKGEN];

    logic              hit_relay;
    logic              hit_porten;
    logic              hit_stamp;
    logic              global_inst1;
    logic [REG_W-1:0]  sel_val;
    logic [2:0]        sel_words;

    assign global_inst1 = (tgt.blk_type == TYPE_GLOBAL) && (tgt.inst == 4'd1);
    assign hit_relay    = global_inst1 && (tgt.param == 2'd0);
    assign hit_porten   = global_inst1 && (tgt.param == 2'd1);
    assign hit_stamp    = (tgt.blk_type == TYPE_TIMER) && (tgt.inst == 4'd1)
                          && (tgt.param == 2'd1);
    assign relay_out    = relay_q;

    // Purpose: relay and port-enable registers of the global block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relay_q  <= 1'b0;
            porten_q <= '0;
        end else if (wr_en) begin
            if (hit_relay)  relay_q  <= wdata[0];
            if (hit_porten) porten_q <= wdata[4:0];
        end
    end

    // Purpose: 64-bit timestamp register, all four words at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
        end else if (wr_en && hit_stamp) begin
            stamp_q <= wdata;
        end
    end

    // One source select and one ratio register per clock generator.
    for (genvar g = 0; g < NUM_CLKGEN; g++) begin : g_clkgen
        logic        inst_hit;
        logic [1:0]  src_q;
        logic [31:0] ratio_q;

        assign inst_hit = (tgt.blk_type == TYPE_CLKGEN) && (tgt.inst == 4'(g + 1));

        // Purpose: write this generator's registers when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q   <= '0;
                ratio_q <= '0;
            end else if (wr_en && inst_hit) begin
                if (tgt.param == 2'd1) src_q   <= wdata[1:0];
                if (tgt.param == 2'd2) ratio_q <= wdata[31:0];
            end
        end

        assign src_arr[g]   = src_q;
        assign ratio_arr[g] = ratio_q;
    end

    // Purpose: pick the addressed register and its width in words.
    always_comb begin
        sel_val   = '0;
        sel_words = 3'd0;
        if (hit_relay) begin
            sel_val   = REG_W'(relay_q);
            sel_words = 3'd1;
        end else if (hit_porten) begin
            sel_val   = REG_W'(porten_q);
            sel_words = 3'd1;
        end else if (hit_stamp) begin
            sel_val   = stamp_q;
            sel_words = 3'd4;
        end else if (tgt.blk_type == TYPE_CLKGEN) begin
            for (int i = 0; i < NUM_CLKGEN; i++) begin
                if (tgt.inst == 4'(i + 1)) begin
                    if (tgt.param == 2'd1) begin
                        sel_val   = REG_W'(src_arr[i]);
                        sel_words = 3'd1;
                    end else if (tgt.param == 2'd2) begin
                        sel_val   = REG_W'(ratio_arr[i]);
                        sel_words = 3'd2;
                    end
                end
            end
        end
    end

    // Purpose: return the indexed word, zero past the register's width.
    always_comb begin
        if ({1'b0, tgt.idx} < sel_words) begin
            rdata = sel_val[tgt.idx*WORD_W +: WORD_W];
        end else begin
            rdata = '0;
        end
    end

    // R6: without a commit strobe no internal register moves
    a_r6_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(relay_q) && $stable(porten_q) && $stable(stamp_q)));

    // R9: a write that hits nothing in the global block leaves it alone
    a_r9_unmapped_global: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_relay && !hit_porten) |=> ($stable(relay_q) && $stable(porten_q)));

endmodule

// File: rtl/indirect_reg_bridge.sv
// Module: top of the indirect register access bridge.
// Connects the host window, the transaction sequencer and the internal
// register bank. Assumes a single clock and synchronous active-low reset.
module indirect_reg_bridge
    import ibr_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int NUM_CLKGEN  = 3,
    parameter int BOARD_REV   = 5,
    parameter int MAJOR_REV   = 2,
    parameter int MINOR_REV   = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_off,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        audio_present,
    output logic        quad_mode,
    output logic        glob_rst_n,
    output logic        codec_rst_n,
    output logic        relay_out
);

    logic                       busy;
    logic                       launch;
    ibr_target_t                launch_tgt;
    ibr_target_t                tgt;
    logic [NUM_DATA*WORD_W-1:0] data_flat;
    logic [NUM_DATA*WORD_W-1:0] wdata;
    logic                       commit_wr;
    logic                       commit_rd;
    logic [WORD_W-1:0]          rf_rdata;

    ibr_window #(
        .BOARD_REV (BOARD_REV),
        .MAJOR_REV (MAJOR_REV),
        .MINOR_REV (MINOR_REV)
    ) u_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_off      (host_off),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .audio_present (audio_present),
        .busy          (busy),
        .rd_load       (commit_rd),
        .rd_word       (rf_rdata),
        .launch        (launch),
        .launch_tgt    (launch_tgt),
        .data_flat     (data_flat),
        .quad_mode     (quad_mode),
        .glob_rst_n    (glob_rst_n),
        .codec_rst_n   (codec_rst_n)
    );

    ibr_sequencer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_tgt (launch_tgt),
        .data_flat  (data_flat),
        .busy       (busy),
        .commit_wr  (commit_wr),
        .commit_rd  (commit_rd),
        .tgt        (tgt),
        .wdata      (wdata)
    );

    ibr_regfile #(
        .NUM_CLKGEN (NUM_CLKGEN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit_wr),
        .tgt       (tgt),
        .wdata     (wdata),
        .rdata     (rf_rdata),
        .relay_out (relay_out)
    );

    // R7: the relay pin moves only at a write commit
    a_r7_relay_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_wr |=> $stable(relay_out));

endmodule

// File: tb/indirect_reg_bridge_tb_top.sv
// Bench: scoreboard. Driver tasks push expected values into a queue; a
// monitor at each falling edge pops one item and compares it.
module indirect_reg_bridge_tb_top;

    localparam int BUSY = 4;

    typedef struct {
        string       tag;
        logic [2:0]  off;
        logic        pins;
        logic [15:0] exp;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_off = 3'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        audio_present = 1'b1;
    logic        quad_mode, glob_rst_n, codec_rst_n, relay_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    sb_item_t sb_q[$];
    sb_item_t cur;
    logic [15:0] act;

    always #10 clk = ~clk;   // 50 MHz

    indirect_reg_bridge dut_i (
        .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_off (host_off),
        .host_wdata (host_wdata), .host_rdata (host_rdata),
        .audio_present (audio_present), .quad_mode (quad_mode),
        .glob_rst_n (glob_rst_n), .codec_rst_n (codec_rst_n),
        .relay_out (relay_out)
    );

    // Driver: one host write, captured at the next rising edge.
    task automatic wr(input logic [2:0] off, input logic [15:0] d);
        host_wr = 1'b1; host_off = off; host_wdata = d;
        @(posedge clk); #2;
        host_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    // Driver: expect a slot value (pins = 0) or the pin vector (pins = 1).
    task automatic chk(input string tag, input logic [2:0] off,
                       input logic pins, input logic [15:0] e);
        sb_item_t it;
        it.tag = tag; it.off = off; it.pins = pins; it.exp = e;
        host_wr = 1'b0; host_off = off;
        sb_q.push_back(it);
        @(posedge clk); #2;
    endtask

    // Address write followed by the full busy window.
    task automatic xact(input logic [15:0] a);
        wr(3'd2, a);
        idle(BUSY);
    endtask

    // Monitor: compare at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            act = cur.pins ? {12'd0, relay_out, quad_mode, glob_rst_n, codec_rst_n}
                           : host_rdata;
            n_cmp++;
            if (act !== cur.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R11 / R3 / R2 / R1: reset state of the window
        chk("R3 status reset", 3'd0, 1'b0, 16'h0000);
        chk("R3 pins reset", 3'd0, 1'b1, 16'h0000);
        chk("R2 revision", 3'd1, 1'b0, 16'h5027);
        chk("R11 addr reset", 3'd2, 1'b0, 16'h0000);
        chk("R11 data3 reset", 3'd6, 1'b0, 16'h0000);
        chk("R1 offset7 reads 0", 3'd7, 1'b0, 16'h0000);
        // R2: read-only revision, audio bit inverted
        wr(3'd1, 16'hFFFF);
        chk("R2 revision write ignored", 3'd1, 1'b0, 16'h5027);
        audio_present = 1'b0;
        chk("R2 audio absent bit", 3'd1, 1'b0, 16'hD027);
        audio_present = 1'b1;
        wr(3'd7, 16'hBEEF);
        chk("R1 offset7 write ignored", 3'd7, 1'b0, 16'h0000);
        // R3: control bits
        wr(3'd0, 16'hFFFF);
        chk("R3 status bits", 3'd0, 1'b0, 16'h001C);
        chk("R3 pins set", 3'd0, 1'b1, 16'h0007);
        // R6: data writes only
        wr(3'd3, 16'h0001);
        wr(3'd4, 16'h2222);
        chk("R6 data1 held", 3'd4, 1'b0, 16'h2222);
        chk("R6 relay untouched", 3'd0, 1'b1, 16'h0007);
        // R4 / R10: relay write with busy window
        wr(3'd2, 16'h9100);
        for (int i = 0; i < BUSY; i++) chk("R4 busy high", 3'd0, 1'b0, 16'h001D);
        chk("R4 busy clear", 3'd0, 1'b0, 16'h001C);
        chk("R10 relay pin", 3'd0, 1'b1, 16'h000F);
        chk("R4 addr stored", 3'd2, 1'b0, 16'h9100);
        // R8 / R10: relay read back, index beyond width
        wr(3'd3, 16'hAAAA);
        xact(16'h9180);
        chk("R8 relay read", 3'd3, 1'b0, 16'h0001);
        xact(16'h9181);
        chk("R8 narrow idx1 zero", 3'd3, 1'b0, 16'h0000);
        // R10: port enable masked to 5 bits
        wr(3'd3, 16'hFFFF);
        xact(16'h9104);
        xact(16'h9184);
        chk("R10 port enable", 3'd3, 1'b0, 16'h001F);
        // R7: 64-bit timestamp, data change during busy ignored
        wr(3'd3, 16'h1234); wr(3'd4, 16'h5678);
        wr(3'd5, 16'h9ABC); wr(3'd6, 16'hDEF0);
        wr(3'd2, 16'h3104);
        wr(3'd4, 16'h0000);
        idle(BUSY);
        xact(16'h3184); chk("R7 stamp word0", 3'd3, 1'b0, 16'h1234);
        xact(16'h3185); chk("R7 stamp word1 snapshot", 3'd3, 1'b0, 16'h5678);
        xact(16'h3186); chk("R7 stamp word2", 3'd3, 1'b0, 16'h9ABC);
        xact(16'h3187); chk("R7 stamp word3", 3'd3, 1'b0, 16'hDEF0);
        // R10: clock generator 2
        wr(3'd3, 16'h00AA); wr(3'd4, 16'h00BB);
        xact(16'h2208);
        wr(3'd3, 16'hFFFF);
        xact(16'h2204);
        xact(16'h2288); chk("R10 ratio word0", 3'd3, 1'b0, 16'h00AA);
        xact(16'h2289); chk("R10 ratio word1", 3'd3, 1'b0, 16'h00BB);
        xact(16'h228A); chk("R8 ratio idx2 zero", 3'd3, 1'b0, 16'h0000);
        xact(16'h2284); chk("R10 source 2 bits", 3'd3, 1'b0, 16'h0003);
        xact(16'h2188); chk("R10 clkgen1 untouched", 3'd3, 1'b0, 16'h0000);
        // R9: unmapped addresses
        wr(3'd3, 16'h7777);
        xact(16'h5100);
        xact(16'h5180); chk("R9 unmapped read zero", 3'd3, 1'b0, 16'h0000);
        wr(3'd3, 16'h0000);
        xact(16'h910C);
        chk("R9 relay kept", 3'd0, 1'b1, 16'h000F);
        xact(16'h9184); chk("R9 port enable kept", 3'd3, 1'b0, 16'h001F);
        xact(16'h918C); chk("R9 unmapped param zero", 3'd3, 1'b0, 16'h0000);
        // R5: second address write during busy ignored
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h9180);
        wr(3'd2, 16'h9100);
        idle(BUSY);
        chk("R5 addr kept", 3'd2, 1'b0, 16'h9180);
        chk("R5 relay not written", 3'd0, 1'b1, 16'h000F);
        chk("R5 first read done", 3'd3, 1'b0, 16'h0001);
        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule